// File: doc/BRIEF.md
# CAN Fault-Confinement Counter and Error Log

This block holds the transmit and receive fault-confinement counters of a CAN protocol controller and presents them, together with an error log counter, as one 32-bit read-only status word. The protocol engine drives one-cycle event strobes into the block:

- a transmit error, with the amount to add;
- a receive error, with the amount to add;
- a successful transmit;
- a successful receive;
- a bus-off recovery.

The block keeps the counters and exposes them continuously.

The error log counter counts every protocol error that would raise either fault counter. Reading the status word clears it. It stops at its maximum value. Once it is full, the next error produces a one-cycle overflow interrupt pulse, and an external interrupt register is expected to latch that pulse.

A restricted-operation mode bit freezes both fault counters against errors while the log keeps counting. The receive counter is held internally one bit wider than its field, so that it can reach the passive level. The field reports the low bits, and a separate flag reports the passive state.

Top module: `can_ecl_top`

## Requirements
- R1: After reset, the status word, the passive flag and the overflow interrupt are all zero.
- R2: The status word carries the transmit count in bits 7:0, the low 7 bits of the receive count in bits 14:8, the receive-passive flag in bit 15 and the log count in bits 23:16. Bits 31:24 always read zero.
- R3: A transmit error strobe adds its increment amount to the transmit counter. The counter saturates at 255 and does not wrap.
- R4: A receive error strobe adds its increment amount to the 8-bit internal receive counter, which saturates at 255. The passive flag (status bit 15 and its own output) is 1 exactly when that count is 128 or more.
- R5: A success strobe decrements its own counter by one and never goes below zero. An error strobe in the same cycle takes priority, and the decrement is dropped.
- R6: A bus-off recovery strobe clears both fault counters and the passive flag, with priority over every other event. It leaves the log counter unchanged.
- R7: The log counter rises by exactly one in each cycle that carries a transmit error, a receive error or both.
- R8: A read strobe clears the log counter. The status word seen during the read cycle still shows the old value. If an error arrives in the same cycle as the read, the log ends at one.
- R9: The log counter saturates at 255. An error that arrives while it is at 255, without a read in the same cycle, pulses the overflow interrupt high for exactly the next cycle.
- R10: While restricted mode is 1, error strobes leave both fault counters unchanged but still advance the log counter. Success and recovery strobes keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_err_i | input | 1 | Transmit protocol error strobe |
| tx_err_inc_i | input | 4 | Amount added on a transmit error |
| rx_err_i | input | 1 | Receive protocol error strobe |
| rx_err_inc_i | input | 4 | Amount added on a receive error |
| tx_ok_i | input | 1 | Successful transmit strobe |
| rx_ok_i | input | 1 | Successful receive strobe |
| busoff_rec_i | input | 1 | Bus-off recovery strobe |
| restrict_i | input | 1 | Restricted-operation mode |
| rd_i | input | 1 | Status word read strobe |
| status_o | output | 32 | Packed status word |
| rx_passive_o | output | 1 | Receive-error-passive flag |
| log_ovf_irq_o | output | 1 | One-cycle log overflow interrupt pulse |

## Verification
The bench builds the block with its default widths: an 8-bit transmit counter, a 7-bit receive field, an 8-bit log and a 4-bit increment. With these widths, transmit saturation takes 32 errors of eight and the passive threshold takes 16 receive errors of eight. Log saturation and the overflow pulse take 256 errors, a few hundred cycles in all, so every saturation boundary is reached directly. The 4-bit increment covers the usual amounts of one and eight, and also the zero amount used to advance the log without moving a counter.

// File: rtl/can_ecl_pkg.sv
// Package: shared counter operation type for the CAN error counter block.
// Assumes one operation per counter per cycle, with priority already resolved.
package can_ecl_pkg;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_CLR  = 2'd1,
        CNT_ADD  = 2'd2,
        CNT_SUB  = 2'd3
    } cnt_op_e;

    // Resolve one counter's operation: clear beats add, add beats subtract.
    function automatic cnt_op_e sel_op(input logic clr, input logic add, input logic sub);
        if (clr)      return CNT_CLR;
        else if (add) return CNT_ADD;
        else if (sub) return CNT_SUB;
        else          return CNT_HOLD;
    endfunction

endpackage

// File: rtl/can_ecl_sat_cnt.sv
// Module: saturating up/down counter for one fault-confinement count.
// Adds a variable amount with saturation at all-ones, subtracts one with a
// floor at zero, or clears. Assumes INC_W <= WIDTH.
module can_ecl_sat_cnt
    import can_ecl_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cnt_op_e          op_i,
    input  logic [INC_W-1:0] amt_i,
    output logic [WIDTH-1:0] cnt_o
);

    localparam logic [WIDTH-1:0] MAXV = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] cnt_d;
    logic [WIDTH:0]   sum;

    // Next count from the resolved operation.
    always_comb begin
        sum   = {1'b0, cnt_q} + {{(WIDTH + 1 - INC_W){1'b0}}, amt_i};
        cnt_d = cnt_q;
        unique case (op_i)
            CNT_CLR:  cnt_d = '0;
            CNT_ADD:  cnt_d = sum[WIDTH] ? MAXV : sum[WIDTH-1:0];
            CNT_SUB:  cnt_d = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
            default:  cnt_d = cnt_q;
        endcase
    end

    // Count register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/can_ecl_log.sv
// Module: error log counter with clear-on-read and an overflow pulse.
// Counts one per error cycle and sticks at all-ones. An error arriving while
// full, with no read in the same cycle, gives a one-cycle registered pulse.
// A read clears the count, and an error in the read cycle leaves it at one.
module can_ecl_log #(
    parameter int LOG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_i,
    input  logic             rd_i,
    output logic [LOG_W-1:0] log_o,
    output logic             ovf_o
);

    localparam logic [LOG_W-1:0] MAXV = {LOG_W{1'b1}};

    logic [LOG_W-1:0] log_q;
    logic             ovf_q;
    logic             full;

    assign full = (log_q == MAXV);

    // Log count and overflow pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            log_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= err_i && !rd_i && full;
            if (rd_i)
                log_q <= err_i ? LOG_W'(1) : '0;
            else if (err_i && !full)
                log_q <= log_q + 1'b1;
        end
    end

    assign log_o = log_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/can_ecl_top.sv
// Module: CAN fault-confinement counters with error log, packed into a
// read-only status word. Assumes one-cycle event strobes from the protocol
// engine and a read strobe that lasts one cycle per register access.
module can_ecl_top
    import can_ecl_pkg::*;
#(
    parameter int TEC_W  = 8,
    parameter int REC_W  = 7,
    parameter int LOG_W  = 8,
    parameter int INC_W  = 4,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_err_i,
    input  logic [INC_W-1:0]  tx_err_inc_i,
    input  logic              rx_err_i,
    input  logic [INC_W-1:0]  rx_err_inc_i,
    input  logic              tx_ok_i,
    input  logic              rx_ok_i,
    input  logic              busoff_rec_i,
    input  logic              restrict_i,
    input  logic              rd_i,
    output logic [STAT_W-1:0] status_o,
    output logic              rx_passive_o,
    output logic              log_ovf_irq_o
);

    localparam int RX_IW   = REC_W + 1;
    localparam int REC_LSB = TEC_W;
    localparam int PAS_BIT = TEC_W + REC_W;
    localparam int LOG_LSB = PAS_BIT + 1;
    localparam int USED_W  = LOG_LSB + LOG_W;

    cnt_op_e          tx_op;
    cnt_op_e          rx_op;
    logic [TEC_W-1:0] tec;
    logic [RX_IW-1:0] rec_full;
    logic [LOG_W-1:0] log_cnt;
    logic             any_err;

    // Operation selection: recovery, then unrestricted error, then success.
    always_comb begin
        tx_op   = sel_op(busoff_rec_i, tx_err_i && !restrict_i, tx_ok_i);
        rx_op   = sel_op(busoff_rec_i, rx_err_i && !restrict_i, rx_ok_i);
        any_err = tx_err_i || rx_err_i;
    end

    can_ecl_sat_cnt #(.WIDTH(TEC_W), .INC_W(INC_W)) u_tx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (tx_op),
        .amt_i (tx_err_inc_i),
        .cnt_o (tec)
    );

    can_ecl_sat_cnt #(.WIDTH(RX_IW), .INC_W(INC_W)) u_rx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (rx_op),
        .amt_i (rx_err_inc_i),
        .cnt_o (rec_full)
    );

    can_ecl_log #(.LOG_W(LOG_W)) u_log (
        .clk   (clk),
        .rst_n (rst_n),
        .err_i (any_err),
        .rd_i  (rd_i),
        .log_o (log_cnt),
        .ovf_o (log_ovf_irq_o)
    );

    // Status word packing, with the unused upper bits tied to zero.
    always_comb begin
        status_o                             = '0;
        status_o[REC_LSB-1:0]                = tec;
        status_o[PAS_BIT-1:REC_LSB]          = rec_full[REC_W-1:0];
        status_o[PAS_BIT]                    = rec_full[REC_W];
        status_o[USED_W-1:LOG_LSB]           = log_cnt;
    end

    assign rx_passive_o = rec_full[REC_W];

endmodule

// File: rtl/can_ecl_chk.sv
// Module: assertion checker for can_ecl_top, observing its ports only.
// Assumes the default field layout is derived from the same parameters.
module can_ecl_chk #(
    parameter int TEC_W  = 8,
    parameter int REC_W  = 7,
    parameter int LOG_W  = 8,
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_err_i,
    input logic              rx_err_i,
    input logic              tx_ok_i,
    input logic              busoff_rec_i,
    input logic              restrict_i,
    input logic              rd_i,
    input logic [STAT_W-1:0] status_o,
    input logic              rx_passive_o,
    input logic              log_ovf_irq_o
);

    localparam int LOG_LSB = TEC_W + REC_W + 1;
    localparam logic [LOG_W-1:0] LMAX = {LOG_W{1'b1}};

    logic [TEC_W-1:0] tec;
    logic [REC_W-1:0] rec;
    logic [LOG_W-1:0] lg;
    logic             err;

    assign tec = status_o[TEC_W-1:0];
    assign rec = status_o[TEC_W+REC_W-1:TEC_W];
    assign lg  = status_o[LOG_LSB+LOG_W-1:LOG_LSB];
    assign err = tx_err_i || rx_err_i;

    AST_BUSOFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        busoff_rec_i |=> (tec == '0 && rec == '0 && !rx_passive_o)); // R6
    AST_TEC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (tec == '0 && !tx_err_i) |=> tec == '0); // R5
    AST_TEC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (restrict_i && !busoff_rec_i && !tx_ok_i) |=> $stable(tec)); // R10
    AST_LOG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i && err && lg != LMAX) |=> lg == LOG_W'($past(lg) + 1'b1)); // R7
    AST_LOG_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !err) |=> lg == '0); // R8
    AST_LOG_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && err) |=> lg == LOG_W'(1)); // R8
    AST_LOG_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (lg == LMAX && !rd_i) |=> lg == LMAX); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (lg != LMAX || !err || rd_i) |=> !log_ovf_irq_o); // R9
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (lg == LMAX && err && !rd_i) |=> log_ovf_irq_o); // R9

endmodule

bind can_ecl_top can_ecl_chk #(
    .TEC_W(TEC_W), .REC_W(REC_W), .LOG_W(LOG_W), .STAT_W(STAT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_err_i      (tx_err_i),
    .rx_err_i      (rx_err_i),
    .tx_ok_i       (tx_ok_i),
    .busoff_rec_i  (busoff_rec_i),
    .restrict_i    (restrict_i),
    .rd_i          (rd_i),
    .status_o      (status_o),
    .rx_passive_o  (rx_passive_o),
    .log_ovf_irq_o (log_ovf_irq_o)
);

// File: tb/can_ecl_top_tb_top.sv
// Bench: table-driven walk of mixed events, then directed saturation,
// passive-threshold, overflow and read-timing tests.
module can_ecl_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_err_i = 1'b0;
    logic [3:0]  tx_err_inc_i = '0;
    logic        rx_err_i = 1'b0;
    logic [3:0]  rx_err_inc_i = '0;
    logic        tx_ok_i = 1'b0;
    logic        rx_ok_i = 1'b0;
    logic        busoff_rec_i = 1'b0;
    logic        restrict_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [31:0] status_o;
    logic        rx_passive_o;
    logic        log_ovf_irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    can_ecl_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_err_i      (tx_err_i),
        .tx_err_inc_i  (tx_err_inc_i),
        .rx_err_i      (rx_err_i),
        .rx_err_inc_i  (rx_err_inc_i),
        .tx_ok_i       (tx_ok_i),
        .rx_ok_i       (rx_ok_i),
        .busoff_rec_i  (busoff_rec_i),
        .restrict_i    (restrict_i),
        .rd_i          (rd_i),
        .status_o      (status_o),
        .rx_passive_o  (rx_passive_o),
        .log_ovf_irq_o (log_ovf_irq_o)
    );

    typedef struct packed {
        logic       te;
        logic [3:0] ti;
        logic       re;
        logic [3:0] ri;
        logic       to;
        logic       ro;
        logic       bo;
        logic       rs;
        logic       rd;
        logic [7:0] e_tec;
        logic [6:0] e_rec;
        logic       e_pas;
        logic [7:0] e_log;
        logic       e_irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd8, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  7'd0, 1'b0, 8'd1, 1'b0}, // R3 R7
        '{1'b0, 4'd0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8,  7'd1, 1'b0, 8'd2, 1'b0}, // R4
        '{1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd7,  7'd1, 1'b0, 8'd2, 1'b0}, // R5
        '{1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7,  7'd0, 1'b0, 8'd2, 1'b0}, // R5
        '{1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd7,  7'd0, 1'b0, 8'd2, 1'b0}, // R5 floor
        '{1'b1, 4'd8, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd15, 7'd1, 1'b0, 8'd3, 1'b0}, // R7 both
        '{1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd15, 7'd1, 1'b0, 8'd0, 1'b0}, // R8
        '{1'b1, 4'd8, 1'b0, 4'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd23, 7'd1, 1'b0, 8'd1, 1'b0}, // R8
        '{1'b1, 4'd8, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd23, 7'd1, 1'b0, 8'd2, 1'b0}, // R10
        '{1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd22, 7'd1, 1'b0, 8'd2, 1'b0}, // R10
        '{1'b1, 4'd8, 1'b0, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd30, 7'd1, 1'b0, 8'd3, 1'b0}, // R5 prio
        '{1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd0,  7'd0, 1'b0, 8'd3, 1'b0}  // R6
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle of events at a falling edge, then return to idle at the next one.
    task automatic step(input logic te, input logic [3:0] ti, input logic re, input logic [3:0] ri,
                        input logic to, input logic ro, input logic bo, input logic rs, input logic rd);
        tx_err_i = te; tx_err_inc_i = ti; rx_err_i = re; rx_err_inc_i = ri;
        tx_ok_i = to; rx_ok_i = ro; busoff_rec_i = bo; restrict_i = rs; rd_i = rd;
        @(negedge clk);
        tx_err_i = 1'b0; tx_err_inc_i = '0; rx_err_i = 1'b0; rx_err_inc_i = '0;
        tx_ok_i = 1'b0; rx_ok_i = 1'b0; busoff_rec_i = 1'b0; restrict_i = 1'b0; rd_i = 1'b0;
    endtask

    function automatic logic [31:0] word(input logic [7:0] t, input logic [6:0] r,
                                         input logic p, input logic [7:0] l);
        return {8'h00, l, p, r, t};
    endfunction

    initial begin
        #(8 * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 status", status_o, 32'h0);
        check("R1 flags", {30'h0, rx_passive_o, log_ovf_irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk (R2 layout is checked by the whole-word compare).
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].te, VEC[i].ti, VEC[i].re, VEC[i].ri, VEC[i].to,
                 VEC[i].ro, VEC[i].bo, VEC[i].rs, VEC[i].rd);
            check($sformatf("R2 table row %0d", i), status_o,
                  word(VEC[i].e_tec, VEC[i].e_rec, VEC[i].e_pas, VEC[i].e_log));
            check($sformatf("R9 table irq row %0d", i), {31'h0, log_ovf_irq_o}, {31'h0, VEC[i].e_irq});
        end

        // Transmit saturation: 32 errors of 8 reach 255, one more stays there (R3).
        step(0, 0, 0, 0, 0, 0, 1, 0, 1);
        for (int k = 0; k < 32; k++) step(1, 4'd8, 0, 0, 0, 0, 0, 0, 0);
        check("R3 tx saturate", {24'h0, status_o[7:0]}, 32'd255);
        step(1, 4'd1, 0, 0, 0, 0, 0, 0, 0);
        check("R3 tx stays", {24'h0, status_o[7:0]}, 32'd255);

        // Receive passive threshold (R4).
        step(0, 0, 0, 0, 0, 0, 1, 0, 1);
        for (int k = 0; k < 15; k++) step(0, 0, 1, 4'd8, 0, 0, 0, 0, 0);
        check("R4 rec 120", {16'h0, status_o[15:0]}, {16'h0, 1'b0, 7'd120, 8'd0});
        check("R4 passive low", {31'h0, rx_passive_o}, 32'd0);
        step(0, 0, 1, 4'd8, 0, 0, 0, 0, 0);
        check("R4 rec 128", {16'h0, status_o[15:0]}, {16'h0, 1'b1, 7'd0, 8'd0});
        check("R4 passive high", {31'h0, rx_passive_o}, 32'd1);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);
        check("R4 rec 127", {16'h0, status_o[15:0]}, {16'h0, 1'b0, 7'd127, 8'd0});

        // Bus-off clears and keeps the log (R6).
        step(0, 0, 1, 4'd8, 0, 0, 0, 0, 1);
        step(1, 4'd8, 1, 4'd8, 0, 0, 1, 0, 0);
        check("R6 busoff priority", status_o, word(8'd0, 7'd0, 1'b0, 8'd2));

        // Log saturation and overflow pulse, counters frozen by restricted mode (R9 R10).
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        for (int k = 0; k < 255; k++) step(1, 4'd0, 0, 0, 0, 0, 0, 1, 0);
        check("R9 log full", status_o, word(8'd0, 7'd0, 1'b0, 8'd255));
        check("R9 no irq yet", {31'h0, log_ovf_irq_o}, 32'd0);
        step(0, 0, 1, 4'd8, 0, 0, 0, 1, 0);
        check("R9 irq pulse", {31'h0, log_ovf_irq_o}, 32'd1);
        check("R10 frozen", status_o, word(8'd0, 7'd0, 1'b0, 8'd255));
        @(negedge clk);
        check("R9 irq one cycle", {31'h0, log_ovf_irq_o}, 32'd0);

        // Read during error at full: old value visible, log ends at one, no irq (R8).
        tx_err_i = 1'b1; tx_err_inc_i = 4'd1; rd_i = 1'b1;
        #1;
        check("R8 read sees old", status_o, word(8'd0, 7'd0, 1'b0, 8'd255));
        @(negedge clk);
        tx_err_i = 1'b0; tx_err_inc_i = '0; rd_i = 1'b0;
        check("R8 read+err", status_o, word(8'd1, 7'd0, 1'b0, 8'd1));
        check("R8 no irq on read", {31'h0, log_ovf_irq_o}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule